// File: doc/BRIEF.md
# Delayed Transaction Table with Requester Identity

This block sits on the target side of a bus, or on the near side of a bridge, and handles reads and writes that cannot finish at once. The first time a request arrives, the block stores it in a table slot and answers with a retry. It later forwards the stored request to the completer and keeps the completer's answer in the same slot. The answer is handed back only when the original requester repeats its request.

A stored entry is keyed on four fields: command, address, byte enables and a 4-bit requester tag. The tag is the index of the bus grant given to the requester. Because the tag is part of the key, a request from another requester to the same location cannot take an answer meant for someone else. It gets its own slot instead.

Two slots may hold the same address and byte enables. Only one of them is allowed to be in flight toward the completer at any time. Pending slots are forwarded oldest first, and a slot held back by that rule is skipped until the rule no longer applies. Each completion is tagged with the slot it belongs to, and it is consumed by exactly one matching retry.

Top module: `dly_txn_table`

## Requirements
- R1: A request whose key matches no slot, while a slot is free, is stored in the lowest-numbered free slot. The cycle after `req_valid`, the block raises `rsp_valid` with `rsp_done`=0 (retry).
- R2: A completion (`cpl_valid` with `cpl_tag` naming an in-flight slot) stores `cpl_data` and `cpl_status` in that slot. A later request with the same key gets `rsp_done`=1 with those values one cycle after `req_valid`, and the slot is freed. Repeating that same request afterwards stores a new entry and gets a retry.
- R3: A key matches only when command, address, byte enables and requester tag are all equal. A request that differs only in its tag never receives another slot's data; it is stored in a slot of its own.
- R4: A request that matches a slot still waiting or in flight gets a retry and does not take a new slot.
- R5: No two slots with equal address and byte enables are ever in flight toward the completer at the same time.
- R6: `dn_valid` is high exactly when some waiting slot is not blocked by R5. The slot offered is the oldest of those. A slot moves to in flight on `dn_valid` and `dn_ready`, with `dn_tag` giving its slot number.
- R7: Delayed writes use the same key matching. The write data is not compared. The write data sent downstream is the data from the attempt that created the slot.
- R8: When every slot is occupied and the request matches none, the answer is a retry and nothing is stored.
- R9: While reset is asserted and after it is released, `rsp_valid` and `dn_valid` are low until requests arrive.
- R10: Each completion satisfies at most one request. Any request matches at most one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Incoming request strobe |
| req_cmd | input | CMD_W | Request command |
| req_addr | input | ADDR_W | Request address |
| req_be | input | BE_W | Request byte enables |
| req_mid | input | MID_W | Requester tag (grant index) |
| req_wdata | input | DATA_W | Write data of the request |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_done | output | 1 | 1 = completed, 0 = retry |
| rsp_data | output | DATA_W | Returned data when completed |
| rsp_status | output | STAT_W | Returned termination status when completed |
| dn_valid | output | 1 | A stored request is offered to the completer |
| dn_ready | input | 1 | Completer accepts the offered request |
| dn_tag | output | TAG_W | Slot number of the offered request |
| dn_cmd | output | CMD_W | Offered command |
| dn_addr | output | ADDR_W | Offered address |
| dn_be | output | BE_W | Offered byte enables |
| dn_wdata | output | DATA_W | Offered write data |
| cpl_valid | input | 1 | Completion strobe from the completer |
| cpl_tag | input | TAG_W | Slot the completion belongs to |
| cpl_data | input | DATA_W | Completion data |
| cpl_status | input | STAT_W | Completion termination status |

## Verification
Several rules are checked by the assertions on every cycle. They check that no two in-flight slots share an address and byte enables, that a request hits at most one slot, that a full table with no hit answers with a retry, that completions only land on in-flight slots, and that the picker grants at most one slot and always grants when a slot is eligible. Only the bench scenarios can show the orderings and the data paths, because those need a reference model of the table. These include whether a completion goes to its own requester and not to a second requester at the same address, whether the offered slot really is the oldest eligible one, and whether write data comes from the first attempt.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
   typedef enum logic [1:0] {
      SL_FREE  = 2'd0,
      SL_WAIT  = 2'd1,
      SL_SENT  = 2'd2,
      SL_READY = 2'd3
   } slot_st_e;
endpackage

// File: rtl/dtt_slot.sv
module dtt_slot
   import dtt_pkg::*;
#(
   parameter int CMD_W  = 4,
   parameter int ADDR_W = 32,
   parameter int BE_W   = 4,
   parameter int MID_W  = 4,
   parameter int DATA_W = 32,
   parameter int STAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic              sent,
   input  logic              fill,
   input  logic              release_i,
   input  logic [CMD_W-1:0]  in_cmd,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [BE_W-1:0]   in_be,
   input  logic [MID_W-1:0]  in_mid,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic [DATA_W-1:0] in_data,
   input  logic [STAT_W-1:0] in_stat,
   output slot_st_e          st,
   output logic [CMD_W-1:0]  cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BE_W-1:0]   be,
   output logic [MID_W-1:0]  mid,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] data,
   output logic [STAT_W-1:0] stat
);
   // slot life cycle: free -> waiting -> in flight -> answered -> free
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          st <= SL_FREE;
      else if (alloc)      st <= SL_WAIT;
      else if (sent)       st <= SL_SENT;
      else if (fill)       st <= SL_READY;
      else if (release_i)  st <= SL_FREE;
   end

   always_ff @(posedge clk) begin
      if (alloc) begin
         cmd   <= in_cmd;
         addr  <= in_addr;
         be    <= in_be;
         mid   <= in_mid;
         wdata <= in_wdata;
      end
      if (fill) begin
         data <= in_data;
         stat <= in_stat;
      end
   end

   a_r1_alloc_only_free: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> st == SL_FREE);
   a_r2_fill_only_sent: assert property (@(posedge clk) disable iff (!rst_n)
      fill |-> st == SL_SENT);
   a_r10_release_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |-> st == SL_READY);
endmodule

// File: rtl/dtt_pick.sv
module dtt_pick #(
   parameter int ENTRIES = 4,
   localparam int TAG_W  = $clog2(ENTRIES)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ENTRIES-1:0]               elig,
   input  logic [ENTRIES-1:0][ENTRIES-1:0]  older,
   output logic [ENTRIES-1:0]               grant,
   output logic [TAG_W-1:0]                 gnt_idx,
   output logic                             any
);
   // older[j][i] = 1 means slot j was stored before slot i
   for (genvar i = 0; i < ENTRIES; i++) begin : g_col
      logic [ENTRIES-1:0] col;
      for (genvar j = 0; j < ENTRIES; j++) begin : g_bit
         assign col[j] = older[j][i];
      end
      assign grant[i] = elig[i] & ~|(elig & col);
   end

   assign any = |grant;

   always_comb begin
      gnt_idx = '0;
      for (int k = 0; k < ENTRIES; k++)
         if (grant[k]) gnt_idx = TAG_W'(k);
   end

   a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   a_r6_grant_when_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      (|elig) |-> (|grant));
endmodule

// File: rtl/dly_txn_table.sv
module dly_txn_table
   import dtt_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int CMD_W   = 4,
   parameter int ADDR_W  = 32,
   parameter int BE_W    = 4,
   parameter int MID_W   = 4,
   parameter int DATA_W  = 32,
   parameter int STAT_W  = 2,
   localparam int TAG_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CMD_W-1:0]  req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic [MID_W-1:0]  req_mid,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_data,
   output logic [STAT_W-1:0] rsp_status,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [TAG_W-1:0]  dn_tag,
   output logic [CMD_W-1:0]  dn_cmd,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [BE_W-1:0]   dn_be,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              cpl_valid,
   input  logic [TAG_W-1:0]  cpl_tag,
   input  logic [DATA_W-1:0] cpl_data,
   input  logic [STAT_W-1:0] cpl_status
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("dly_txn_table: ENTRIES must be a power of two, at least 2");
   end
   if (MID_W < 1 || ADDR_W < 1 || BE_W < 1) begin : g_bad_width
      $error("dly_txn_table: key field widths must be positive");
   end

   slot_st_e          st     [ENTRIES];
   logic [CMD_W-1:0]  s_cmd  [ENTRIES];
   logic [ADDR_W-1:0] s_addr [ENTRIES];
   logic [BE_W-1:0]   s_be   [ENTRIES];
   logic [MID_W-1:0]  s_mid  [ENTRIES];
   logic [DATA_W-1:0] s_wdata[ENTRIES];
   logic [DATA_W-1:0] s_data [ENTRIES];
   logic [STAT_W-1:0] s_stat [ENTRIES];

   logic [ENTRIES-1:0] hit, free_v, elig, blocked, grant;
   logic [ENTRIES-1:0] alloc_v, sent_v, fill_v, rel_v;
   logic [ENTRIES-1:0][ENTRIES-1:0] older;
   logic [TAG_W-1:0]   gnt_idx;
   logic               any_hit, full, any_grant;
   logic [DATA_W-1:0]  hit_data;
   logic [STAT_W-1:0]  hit_stat;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      dtt_slot #(
         .CMD_W(CMD_W), .ADDR_W(ADDR_W), .BE_W(BE_W),
         .MID_W(MID_W), .DATA_W(DATA_W), .STAT_W(STAT_W)
      ) i_slot (
         .clk(clk), .rst_n(rst_n),
         .alloc(alloc_v[i]), .sent(sent_v[i]), .fill(fill_v[i]), .release_i(rel_v[i]),
         .in_cmd(req_cmd), .in_addr(req_addr), .in_be(req_be), .in_mid(req_mid),
         .in_wdata(req_wdata), .in_data(cpl_data), .in_stat(cpl_status),
         .st(st[i]), .cmd(s_cmd[i]), .addr(s_addr[i]), .be(s_be[i]), .mid(s_mid[i]),
         .wdata(s_wdata[i]), .data(s_data[i]), .stat(s_stat[i])
      );

      // four-field key match: requester tag is part of the key
      assign hit[i] = (st[i] != SL_FREE) && s_cmd[i] == req_cmd && s_addr[i] == req_addr
                    && s_be[i] == req_be && s_mid[i] == req_mid;
      assign free_v[i] = (st[i] == SL_FREE);

      // held back while another slot for the same location is in flight
      logic [ENTRIES-1:0] same_out;
      for (genvar k = 0; k < ENTRIES; k++) begin : g_blk
         if (k == i) begin : g_self
            assign same_out[k] = 1'b0;
         end else begin : g_other
            assign same_out[k] = (st[k] == SL_SENT) && s_addr[k] == s_addr[i]
                               && s_be[k] == s_be[i];
         end
      end
      assign blocked[i] = |same_out;
      assign elig[i]    = (st[i] == SL_WAIT) && !blocked[i];
      assign sent_v[i]  = grant[i] && dn_ready;
      assign fill_v[i]  = cpl_valid && cpl_tag == TAG_W'(i);
      assign rel_v[i]   = req_valid && hit[i] && st[i] == SL_READY;
   end

   assign any_hit = |hit;
   assign full    = ~|free_v;
   // lowest free slot as a one-hot vector
   assign alloc_v = (req_valid && !any_hit) ? (free_v & (~free_v + 1'b1)) : '0;

   always_comb begin
      hit_data = '0;
      hit_stat = '0;
      for (int k = 0; k < ENTRIES; k++) begin
         if (hit[k]) begin
            hit_data = s_data[k];
            hit_stat = s_stat[k];
         end
      end
   end

   // age matrix: a newly stored slot is younger than every occupied slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         older <= '0;
      end else begin
         for (int a = 0; a < ENTRIES; a++)
            for (int b = 0; b < ENTRIES; b++)
               if (alloc_v[a])      older[a][b] <= 1'b0;
               else if (alloc_v[b]) older[a][b] <= (st[a] != SL_FREE);
      end
   end

   dtt_pick #(.ENTRIES(ENTRIES)) i_pick (
      .clk(clk), .rst_n(rst_n), .elig(elig), .older(older),
      .grant(grant), .gnt_idx(gnt_idx), .any(any_grant)
   );

   assign dn_valid = any_grant;
   assign dn_tag   = gnt_idx;
   assign dn_cmd   = s_cmd[gnt_idx];
   assign dn_addr  = s_addr[gnt_idx];
   assign dn_be    = s_be[gnt_idx];
   assign dn_wdata = s_wdata[gnt_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_done   <= 1'b0;
         rsp_data   <= '0;
         rsp_status <= '0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_done   <= |rel_v;
         rsp_data   <= (|rel_v) ? hit_data : '0;
         rsp_status <= (|rel_v) ? hit_stat : '0;
      end
   end

   a_r10_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $countones(hit) <= 1);
   a_r8_full_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !any_hit && full) |=> (rsp_valid && !rsp_done));
   a_r2_cpl_on_sent: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_valid |-> st[cpl_tag] == SL_SENT);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_chk_i
      for (genvar j = i + 1; j < ENTRIES; j++) begin : g_chk_j
         a_r5_no_twin_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] == SL_SENT && st[j] == SL_SENT)
               |-> !(s_addr[i] == s_addr[j] && s_be[i] == s_be[j]));
      end
   end
endmodule

// File: tb/test_dly_txn_table.sv
`timescale 1ns/1ps
module test_dly_txn_table;
   localparam int N = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n;
   logic req_valid; logic [3:0] req_cmd; logic [31:0] req_addr;
   logic [3:0] req_be; logic [3:0] req_mid; logic [31:0] req_wdata;
   logic rsp_valid, rsp_done; logic [31:0] rsp_data; logic [1:0] rsp_status;
   logic dn_valid, dn_ready; logic [1:0] dn_tag; logic [3:0] dn_cmd;
   logic [31:0] dn_addr; logic [3:0] dn_be; logic [31:0] dn_wdata;
   logic cpl_valid; logic [1:0] cpl_tag; logic [31:0] cpl_data; logic [1:0] cpl_status;

   dly_txn_table i_dly_txn_table (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be),
      .req_mid(req_mid), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_status(rsp_status),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_tag(dn_tag), .dn_cmd(dn_cmd),
      .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data), .cpl_status(cpl_status)
   );

   int total = 0, bad = 0;
   bit finished = 0;

   // reference table: state 0 free, 1 waiting, 2 in flight, 3 answered
   int          ms  [N];
   logic [3:0]  mc  [N];
   logic [31:0] ma  [N];
   logic [3:0]  mb  [N];
   logic [3:0]  mm  [N];
   logic [31:0] mw  [N];
   logic [31:0] md  [N];
   logic [1:0]  mt  [N];
   int          mage[N];
   int          tag2m[N];
   int          seq = 0;
   int          icnt = 0;
   int          cq[$];

   bit          pend = 0;
   bit          e_done;
   logic [31:0] e_data;
   logic [1:0]  e_st;
   string       e_tag;

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int find(logic [3:0] c, logic [31:0] a, logic [3:0] b, logic [3:0] m);
      for (int k = 0; k < N; k++)
         if (ms[k] != 0 && mc[k] == c && ma[k] == a && mb[k] == b && mm[k] == m) return k;
      return -1;
   endfunction

   function automatic int oldest_elig();
      int best = -1;
      for (int k = 0; k < N; k++) begin
         bit blk = 0;
         if (ms[k] != 1) continue;
         for (int q = 0; q < N; q++)
            if (q != k && ms[q] == 2 && ma[q] == ma[k] && mb[q] == mb[k]) blk = 1;
         if (blk) continue;
         if (best < 0 || mage[k] < mage[best]) best = k;
      end
      return best;
   endfunction

   function automatic bit has_twin_other_mid(logic [3:0] c, logic [31:0] a, logic [3:0] b, logic [3:0] m);
      for (int k = 0; k < N; k++)
         if (ms[k] != 0 && mc[k] == c && ma[k] == a && mb[k] == b && mm[k] != m) return 1;
      return 0;
   endfunction

   task automatic cycle(bit rq, logic [3:0] c, logic [31:0] a, logic [3:0] b, logic [3:0] m,
                        logic [31:0] w, bit rdy, bit cpl_en);
      int e, h, fr;
      @(negedge clk);
      if (pend) begin
         check(rsp_valid == 1'b1, e_tag, "rsp_valid", rsp_valid, 1);
         check(rsp_done == e_done, e_tag, "rsp_done", rsp_done, e_done);
         if (e_done) begin
            check(rsp_data == e_data, e_tag, "rsp_data", rsp_data, e_data);
            check(rsp_status == e_st, e_tag, "rsp_status", rsp_status, e_st);
         end
      end else begin
         check(rsp_valid == 1'b0, "R1", "rsp_valid idle", rsp_valid, 0);
      end
      // downstream offer against the reference (R5 R6 R7)
      e = oldest_elig();
      if (e < 0) begin
         check(dn_valid == 1'b0, "R5 R6", "dn_valid", dn_valid, 0);
      end else begin
         check(dn_valid == 1'b1, "R6", "dn_valid", dn_valid, 1);
         check(dn_addr == ma[e] && dn_be == mb[e] && dn_cmd == mc[e], "R6", "dn_addr oldest",
               dn_addr, ma[e]);
         check(dn_wdata == mw[e], "R7", "dn_wdata", dn_wdata, mw[e]);
      end
      // request
      pend = rq;
      if (rq) begin
         h = find(c, a, b, m);
         if (h >= 0 && ms[h] == 3) begin
            e_done = 1; e_data = md[h]; e_st = mt[h]; e_tag = "R2 R10"; ms[h] = 0;
         end else if (h >= 0) begin
            e_done = 0; e_tag = "R4";
         end else begin
            fr = -1;
            for (int k = N - 1; k >= 0; k--) if (ms[k] == 0) fr = k;
            e_done = 0;
            if (fr < 0) e_tag = "R8";
            else begin
               e_tag = has_twin_other_mid(c, a, b, m) ? "R3" : "R1";
               ms[fr] = 1; mc[fr] = c; ma[fr] = a; mb[fr] = b; mm[fr] = m; mw[fr] = w;
               mage[fr] = seq; seq++;
            end
         end
      end
      // completion for a slot already in flight
      cpl_valid = 0; cpl_tag = 0; cpl_data = 0; cpl_status = 0;
      if (cpl_en && cq.size() > 0) begin
         int pick = $urandom_range(0, cq.size() - 1);
         int t = cq[pick];
         int mi = tag2m[t];
         cq.delete(pick);
         icnt++;
         cpl_valid = 1; cpl_tag = 2'(t);
         cpl_data = 32'hC000_0000 | 32'(icnt); cpl_status = 2'(icnt);
         ms[mi] = 3; md[mi] = cpl_data; mt[mi] = cpl_status;
      end
      // issue handshake
      if (rdy && e >= 0 && dn_valid) begin
         tag2m[dn_tag] = e; ms[e] = 2; cq.push_back(int'(dn_tag));
      end
      req_valid = rq; req_cmd = c; req_addr = a; req_be = b; req_mid = m; req_wdata = w;
      dn_ready = rdy;
   endtask

   task automatic idle(bit rdy, bit cpl_en);
      cycle(0, 0, 0, 0, 0, 0, rdy, cpl_en);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int k = 0; k < N; k++) begin ms[k] = 0; tag2m[k] = 0; mage[k] = 0; end
      rst_n = 0; req_valid = 0; req_cmd = 0; req_addr = 0; req_be = 0; req_mid = 0;
      req_wdata = 0; dn_ready = 0; cpl_valid = 0; cpl_tag = 0; cpl_data = 0; cpl_status = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rsp_valid == 0, "R9", "rsp_valid in reset", rsp_valid, 0);
      check(dn_valid == 0, "R9", "dn_valid in reset", dn_valid, 0);
      rst_n = 1;
      @(negedge clk);
      check(rsp_valid == 0 && dn_valid == 0, "R9", "outputs after reset", {rsp_valid, dn_valid}, 0);

      // directed: answer kept for its own requester (R1 R3 R2)
      cycle(1, 4'h6, 32'h200, 4'hF, 4'd1, 32'h11, 0, 0);
      idle(1, 0);
      idle(0, 1);
      cycle(1, 4'h6, 32'h200, 4'hF, 4'd2, 32'h22, 0, 0);
      cycle(1, 4'h6, 32'h200, 4'hF, 4'd1, 32'h11, 0, 0);
      cycle(1, 4'h6, 32'h200, 4'hF, 4'd1, 32'h11, 0, 0);
      repeat (8) idle(1, 1);
      cycle(1, 4'h6, 32'h200, 4'hF, 4'd1, 32'h11, 0, 0);
      cycle(1, 4'h6, 32'h200, 4'hF, 4'd2, 32'h22, 0, 0);
      idle(0, 0);

      // directed: two requesters, same location, one in flight at a time (R5)
      cycle(1, 4'h7, 32'h300, 4'h3, 4'd1, 32'hAAAA, 0, 0);
      cycle(1, 4'h7, 32'h300, 4'h3, 4'd2, 32'hBBBB, 0, 0);
      idle(1, 0);
      idle(1, 0);
      idle(1, 0);
      repeat (6) idle(1, 1);
      // write retried with other data still completes (R7)
      cycle(1, 4'h7, 32'h300, 4'h3, 4'd1, 32'h5555, 0, 0);
      cycle(1, 4'h7, 32'h300, 4'h3, 4'd2, 32'h6666, 0, 0);
      idle(0, 0);

      // directed: full table (R8)
      for (int k = 0; k < 5; k++)
         cycle(1, 4'h6, 32'h400 + 32'(k * 4), 4'hF, 4'd3, 32'(k), 0, 0);
      idle(0, 0);
      repeat (10) idle(1, 1);
      for (int k = 0; k < 5; k++)
         cycle(1, 4'h6, 32'h400 + 32'(k * 4), 4'hF, 4'd3, 32'(k), 0, 0);
      repeat (10) idle(1, 1);
      for (int k = 0; k < 5; k++)
         cycle(1, 4'h6, 32'h400 + 32'(k * 4), 4'hF, 4'd3, 32'(k), 0, 0);

      // random traffic on a small key space
      for (int n = 0; n < 6000; n++) begin
         bit rq = $urandom_range(0, 99) < 60;
         logic [3:0] c = $urandom_range(0, 1) ? 4'h6 : 4'h7;
         logic [31:0] a = 32'h1000 + 32'($urandom_range(0, 1) * 4);
         logic [3:0] b = ($urandom_range(0, 9) == 0) ? 4'h3 : 4'hF;
         logic [3:0] m = 4'($urandom_range(1, 2));
         cycle(rq, c, a, b, m, $urandom, $urandom_range(0, 99) < 50, $urandom_range(0, 99) < 35);
      end
      idle(0, 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule